// File: doc/BRIEF.md
# DRAM Activation Throttle Limiter

This block limits how many DRAM row activations may be issued within a repeating evaluation window. Each activation request is counted. Once the count for the current window goes past a programmable threshold, the activation-allow output drops. It stays low until the window ends. The threshold is written as a low-limit value in units of four activations. A value of zero turns throttling off.

Throttling is armed by an enable bit in a control byte. The limit and the enable are written into staged copies, and those copies take effect at the next window boundary. The one exception is clearing the enable bit: that releases the gate at once.

A free-running prescaler produces the window boundaries. The window is either long, which is the default, or short, which is 4096 times shorter. A short window bounds how long a gate can hold. Short mode is accepted only while the global activation limit input reads zero.

Top module: `act_throttle`

## Requirements
- R1: After reset, `act_allow` is high, `short_mode` is low, and the window length is the long window.
- R2: A low-limit value of 0 never gates activations, even with the enable bit set.
- R3: With low-limit N (1..168) armed, the first 4·N+1 requests of a window see `act_allow` high. After the (4·N+1)th request is counted, `act_allow` is low.
- R4: A written low-limit above 168 is clamped to 168, so 673 requests are allowed and then the gate closes.
- R5: Register select 0 holds the low-limit byte. Register select 1 holds the control byte, whose bit 0 is the enable. A written limit and a set enable apply only from the next window boundary. While the enable is not applied, no gating occurs.
- R6: Once the gate closes it stays closed until the window boundary. At the boundary the request count returns to zero and `act_allow` goes high.
- R7: Register select 2, bit 0, requests short-window mode. When `gbl_act_lim` is zero at write time, short mode applies from the next boundary. The window is then SHORT_WIN cycles, against SHORT_WIN·4096 cycles in long mode.
- R8: A short-mode request written while `gbl_act_lim` is nonzero is refused, and the long window stays in effect.
- R9: Writing the control byte with bit 0 clear releases a closed gate on the next cycle, without waiting for a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 limit, 1 control, 2 window mode |
| cfg_wdata | input | 8 | Register write data |
| gbl_act_lim | input | 8 | Global activation limit; short mode needs zero |
| act_req | input | 1 | Activation request strobe, one per cycle |
| act_allow | output | 1 | High when activations may proceed |
| win_end | output | 1 | High in the last cycle of each window |
| short_mode | output | 1 | Short window currently in effect |

## Verification
The bench builds the block with SHORT_WIN = 2, so the long window is 8192 cycles and the short window is 2 cycles. At that size, bursts that reach the clamped 673-request ceiling fit inside a single long window. Several full long windows also fit in the run, which lets the bench measure both window lengths exactly and wait out a held gate to its boundary.

// File: rtl/act_throttle.sv
module act_throttle #(
  parameter int SHORT_WIN = 64,
  parameter int LONG_MULT = 4096,
  parameter int LIM_MAX   = 168
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic [7:0] gbl_act_lim,
  input  logic       act_req,
  output logic       act_allow,
  output logic       win_end,
  output logic       short_mode
);
  localparam int LONG_WIN = SHORT_WIN * LONG_MULT;
  localparam int WW       = $clog2(LONG_WIN);
  localparam int CNT_SAT  = 4 * LIM_MAX + 1;
  localparam int CW       = $clog2(CNT_SAT + 1);

  logic [WW-1:0] win_cnt;
  logic [CW-1:0] act_cnt;
  logic [7:0]    lim_pend, lim_act;
  logic          en_pend, en_act, mode_pend;

  wire [7:0]    lim_wr   = (cfg_wdata > 8'(LIM_MAX)) ? 8'(LIM_MAX) : cfg_wdata;
  wire          wr_lim   = cfg_we && cfg_sel == 2'd0;
  wire          wr_ctl   = cfg_we && cfg_sel == 2'd1;
  wire          wr_mode  = cfg_we && cfg_sel == 2'd2;
  wire [WW-1:0] win_last = short_mode ? WW'(SHORT_WIN - 1) : WW'(LONG_WIN - 1);
  wire [CW-1:0] thresh   = CW'({lim_act, 2'b00});
  wire          armed    = en_act && lim_act != 8'd0;

  assign win_end   = win_cnt == win_last;
  assign act_allow = !(armed && act_cnt > thresh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_pend  <= '0;
      en_pend   <= 1'b0;
      mode_pend <= 1'b0;
    end else begin
      if (wr_lim)  lim_pend  <= lim_wr;
      if (wr_ctl)  en_pend   <= cfg_wdata[0];
      if (wr_mode) mode_pend <= cfg_wdata[0] && gbl_act_lim == 8'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      act_cnt    <= '0;
      lim_act    <= '0;
      en_act     <= 1'b0;
      short_mode <= 1'b0;
    end else if (win_end) begin
      win_cnt    <= '0;
      act_cnt    <= '0;
      lim_act    <= lim_pend;
      en_act     <= en_pend && !(wr_ctl && !cfg_wdata[0]);
      short_mode <= mode_pend;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (act_req && act_cnt != CW'(CNT_SAT)) act_cnt <= act_cnt + 1'b1;
      if (wr_ctl && !cfg_wdata[0]) en_act <= 1'b0;
    end
  end
endmodule

module act_throttle_chk #(
  parameter int LIM_MAX = 168
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [1:0] cfg_sel,
  input logic [7:0] cfg_wdata,
  input logic       act_req,
  input logic       act_allow,
  input logic       win_end,
  input logic       short_mode,
  input logic [7:0] lim_act
);
  // R4
  limit_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim_act <= 8'(LIM_MAX));
  // R3
  gate_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_allow) |-> $past(act_req));
  // R6
  open_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> act_allow);
  // R9
  release_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_allow) |-> ($past(win_end) || $past(cfg_we && cfg_sel == 2'd1 && !cfg_wdata[0])));
  // R7
  mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (short_mode != $past(short_mode)) |-> $past(win_end));
endmodule

bind act_throttle act_throttle_chk #(.LIM_MAX(LIM_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .act_req(act_req), .act_allow(act_allow),
  .win_end(win_end), .short_mode(short_mode), .lim_act(lim_act)
);

// File: tb/act_throttle_tb.sv
`timescale 1ns/1ps
module act_throttle_tb;
  localparam int SW = 2;
  localparam int LW = SW * 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] gbl_act_lim = '0;
  logic act_req = 1'b0;
  logic act_allow, win_end, short_mode;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  act_throttle #(.SHORT_WIN(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .gbl_act_lim(gbl_act_lim), .act_req(act_req),
    .act_allow(act_allow), .win_end(win_end), .short_mode(short_mode)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic to_boundary();
    while (!win_end) @(negedge clk);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic burst(int n, output int allowed);
    allowed = 0;
    for (int i = 0; i < n; i++) begin
      act_req = 1'b1;
      if (act_allow) allowed++;
      @(posedge clk); @(negedge clk);
    end
    act_req = 1'b0;
  endtask

  task automatic measure(string req, int exp);
    int k;
    to_boundary();
    k = 1;
    while (!win_end) begin @(negedge clk); k++; end
    check(req, k, exp);
  endtask

  task automatic t_reset();
    check("R1 allow", int'(act_allow), 1);
    check("R1 short_mode", int'(short_mode), 0);
    measure("R1 long window", LW);
  endtask

  task automatic t_enable_staging();
    int a;
    wr(2'd0, 8'd2);
    to_boundary();
    burst(20, a);
    check("R5 unarmed all allowed", a, 20);
    wr(2'd1, 8'h01);
    burst(20, a);
    check("R5 enable not yet applied", a, 20);
    to_boundary();
  endtask

  task automatic t_gate_hold();
    int a;
    burst(9, a);
    check("R3 allowed before gate", a, 9);
    check("R3 gate closed", int'(act_allow), 0);
    burst(5, a);
    check("R6 held during burst", a, 0);
    repeat (100) @(negedge clk);
    check("R6 held while idle", int'(act_allow), 0);
    to_boundary();
    check("R6 reopened at boundary", int'(act_allow), 1);
  endtask

  task automatic t_disable_release();
    int a;
    burst(9, a);
    check("R9 gate closed", int'(act_allow), 0);
    wr(2'd1, 8'h00);
    check("R9 immediate release", int'(act_allow), 1);
    burst(30, a);
    check("R9 stays open disabled", a, 30);
    wr(2'd1, 8'h01);
    to_boundary();
  endtask

  task automatic t_clamp();
    int a;
    wr(2'd0, 8'd255);
    to_boundary();
    burst(673, a);
    check("R4 clamped allowance", a, 673);
    check("R4 gate after 673", int'(act_allow), 0);
    to_boundary();
  endtask

  task automatic t_zero_limit();
    int a;
    wr(2'd0, 8'd0);
    to_boundary();
    burst(700, a);
    check("R2 limit zero never gates", a, 700);
  endtask

  task automatic t_short_refused();
    gbl_act_lim = 8'd5;
    wr(2'd2, 8'h01);
    gbl_act_lim = 8'd0;
    to_boundary();
    check("R8 short refused", int'(short_mode), 0);
    measure("R8 still long", LW);
  endtask

  task automatic t_short_accepted();
    wr(2'd2, 8'h01);
    to_boundary();
    check("R7 short applied", int'(short_mode), 1);
    measure("R7 short window", SW);
    measure("R7 short window again", SW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_staging();
    t_gate_hold();
    t_disable_release();
    t_clamp();
    t_zero_limit();
    t_short_refused();
    t_short_accepted();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule